// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit sits beside the timekeeping counters of a real-time clock. It watches the running minute, hour, day-of-month and weekday values, all in BCD, and compares each one against its own programmable alarm register. Each alarm register has an active-low enable in bit 7. Only the fields whose enable bit is clear take part in the comparison. Enabling only the minute field fires the alarm once an hour. Enabling the minute, hour and weekday fields fires it once a week. Other mixes give the rates in between.

When every enabled field matches at once, the unit sets a sticky alarm flag. The flag responds to the rising edge of the match condition. A match that lasts a whole minute therefore sets the flag only once, and software can clear the flag during that minute without it being set again at once. An interrupt enable bit gates the flag onto an active-low interrupt output. Software reaches the alarm registers, the flag and the interrupt enable through a simple single-cycle write port and a combinational read port. Both ports share one address.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, the four alarm registers (address 1 minute, 2 hour, 3 day, 4 weekday) read 0x80, the control register (address 0: bit 0 flag, bit 1 interrupt enable) reads 0x00, and irq_no is high.
- R2: A write stores bit 7 and the field's value bits: bits 6:0 for minute, bits 5:0 for hour and day, bits 2:0 for weekday. The remaining bits read 0.
- R3: A field takes part in the match only while its bit 7 is 0. The time value on a disabled field has no effect on the flag.
- R4: When every enabled field equals its time input, the flag reads 1 after the next clock edge.
- R5: With all four enable bits at 1, the flag never sets, whatever the time inputs are.
- R6: Once set, the flag stays 1 after the match ends.
- R7: Only a write of 0 to control bit 0 clears the flag. Writing 1 there does not set it.
- R8: The flag sets only on a rising match condition. After a clear during a match that is still valid, the flag stays 0 until the match drops and returns.
- R9: irq_no is low exactly when the flag and the interrupt enable (control bit 1) are both 1.
- R10: If a rising match and a clearing write occur in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data at addr_i |
| min_i | input | 7 | Current minute, BCD |
| hour_i | input | 6 | Current hour, BCD |
| day_i | input | 6 | Current day of month, BCD |
| wday_i | input | 3 | Current weekday |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
The hardest case to reach from the ports is the edge-versus-level behaviour: a match held across a clear, and a clear written in the same cycle as the match rises. The bench holds the time inputs steady on a match, clears the flag, and waits several cycles. It then drops the match and brings it back. Separately, it lines up the clearing write with the cycle in which the time inputs first match. A sweep over all 16 enable combinations and all 16 per-field match/mismatch patterns covers the rate selection. Each trial is first primed with a fully mismatched time so that the rising edge is always fresh.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int VAL_W      = 7;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;

  // BCD widths: minute, hour, day, weekday
  localparam int FIELD_W [NUM_FIELDS] = '{7, 6, 6, 3};

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_DAY  = 3'd3,
    REG_WDAY = 3'd4
  } reg_addr_e;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic                              flag_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_FIELDS-1:0][VAL_W-1:0]  val_o,
  output logic [NUM_FIELDS-1:0]             dis_o,
  output logic                              ie_o,
  output logic                              clr_o
);
  logic [NUM_FIELDS-1:0][VAL_W-1:0] val_q;
  logic [NUM_FIELDS-1:0]            dis_q;
  logic                             ie_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [VAL_W-1:0] MASK = VAL_W'((1 << FIELD_W[g]) - 1);
    logic sel;
    assign sel = wr_en_i && (addr_i == ADDR_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[g] <= '0;
        dis_q[g] <= 1'b1;
      end else if (sel) begin
        val_q[g] <= wdata_i[VAL_W-1:0] & MASK;
        dis_q[g] <= wdata_i[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ie_q <= 1'b0;
    else if (wr_en_i && addr_i == REG_CTRL)      ie_q <= wdata_i[CTRL_IE_BIT];
  end

  assign clr_o = wr_en_i && (addr_i == REG_CTRL) && !wdata_i[CTRL_FLAG_BIT];
  assign val_o = val_q;
  assign dis_o = dis_q;
  assign ie_o  = ie_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_CTRL) begin
      rdata_o[CTRL_FLAG_BIT] = flag_i;
      rdata_o[CTRL_IE_BIT]   = ie_q;
    end else if (addr_i >= ADDR_W'(1) && addr_i <= ADDR_W'(NUM_FIELDS)) begin
      rdata_o = {dis_q[addr_i - 1], val_q[addr_i - 1]};
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] val_i,
  input  logic [NUM_FIELDS-1:0]            dis_i,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] now_i,
  output logic                             cond_o
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign hit[g] = dis_i[g] || (val_i[g] == now_i[g]);
  end

  // no enabled field means no alarm at all
  assign cond_o = !(&dis_i) && (&hit);
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic clr_i,
  output logic flag_o
);
  logic cond_q, flag_q, rise;

  assign rise = cond_i && !cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (rise)       flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_SET_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> flag_q); // R4
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !rise) |=> !flag_q); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !flag_q); // R7
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [6:0]        min_i,
  input  logic [5:0]        hour_i,
  input  logic [5:0]        day_i,
  input  logic [2:0]        wday_i,
  output logic              irq_no
);
  logic [NUM_FIELDS-1:0][VAL_W-1:0] val, now;
  logic [NUM_FIELDS-1:0]            dis;
  logic ie, clr, cond, flag;

  assign now[0] = VAL_W'(min_i);
  assign now[1] = VAL_W'(hour_i);
  assign now[2] = VAL_W'(day_i);
  assign now[3] = VAL_W'(wday_i);

  cal_alarm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .flag_i(flag), .rdata_o, .val_o(val), .dis_o(dis), .ie_o(ie), .clr_o(clr)
  );

  cal_alarm_cmp u_cmp (.val_i(val), .dis_i(dis), .now_i(now), .cond_o(cond));

  cal_alarm_flag u_flag (.clk_i, .rst_ni, .cond_i(cond), .clr_i(clr), .flag_o(flag));

  assign irq_no = !(flag && ie);

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ie); // R9
  AST_IDLE_NO_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis) |-> !cond); // R5
endmodule

// File: tb/cal_alarm_unit_test.sv
module cal_alarm_unit_test;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [6:0] min_t = 0;
  logic [5:0] hour_t = 0, day_t = 0;
  logic [2:0] wday_t = 0;
  logic       irq_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_alarm_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .min_i(min_t), .hour_i(hour_t), .day_i(day_t), .wday_i(wday_t),
    .irq_no(irq_n)
  );

  localparam logic [6:0] A_MIN = 7'h45, X_MIN = 7'h12;
  localparam logic [5:0] A_HR = 6'h23, X_HR = 6'h08, A_DAY = 6'h31, X_DAY = 6'h01;
  localparam logic [2:0] A_WD = 3'd6, X_WD = 3'd2;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_time(input logic [3:0] m);
    min_t  = m[0] ? A_MIN : X_MIN;
    hour_t = m[1] ? A_HR  : X_HR;
    day_t  = m[2] ? A_DAY : X_DAY;
    wday_t = m[3] ? A_WD  : X_WD;
  endtask

  function automatic logic flag_now();
    return irq_n ? 1'b0 : 1'b1; // valid while ie=1
  endfunction

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 1; a <= 4; a++) begin rd(3'(a), r); check("R1", r, 8'h80); end
    rd(0, r); check("R1", r, 8'h00);
    check("R1 irq", {7'd0, irq_n}, 8'h01);
    // R2 width masking
    wr(1, 8'hFF); rd(1, r); check("R2 min", r, 8'hFF);
    wr(2, 8'hFF); rd(2, r); check("R2 hour", r, 8'hBF);
    wr(3, 8'h7F); rd(3, r); check("R2 day", r, 8'h3F);
    wr(4, 8'hFF); rd(4, r); check("R2 wday", r, 8'h87);
    // R3 R4 R5 sweep: enable combos x match patterns
    for (int e = 0; e < 16; e++) begin
      wr(1, {~e[0], A_MIN});
      wr(2, {~e[1], 1'b0, A_HR});
      wr(3, {~e[2], 1'b0, A_DAY});
      wr(4, {~e[3], 4'b0, A_WD});
      for (int m = 0; m < 16; m++) begin
        logic exp_f;
        @(negedge clk); set_time(4'd0);
        wr(0, 8'h02);
        @(negedge clk); set_time(4'(m));
        @(negedge clk);
        exp_f = (e != 0) && ((4'(e) & ~4'(m)) == 4'd0);
        rd(0, r);
        check(e == 0 ? "R5" : "R3/R4", r, {6'd0, 1'b1, exp_f});
        check("R9 irq", {7'd0, irq_n}, {7'd0, ~exp_f});
      end
    end
    // enable minute only; current time mismatched
    wr(1, {1'b0, A_MIN}); wr(2, 8'h80); wr(3, 8'h80); wr(4, 8'h80);
    @(negedge clk); set_time(4'd0); wr(0, 8'h02);
    // R7: writing 1 to flag bit does not set
    wr(0, 8'h03); rd(0, r); check("R7 no set", r, 8'h02);
    // R4 then R6 sticky
    @(negedge clk); set_time(4'd1);
    @(negedge clk); check("R4", {7'd0, flag_now()}, 8'h01);
    set_time(4'd0);
    repeat (3) @(negedge clk); check("R6", {7'd0, flag_now()}, 8'h01);
    wr(0, 8'h03); check("R7 keep", {7'd0, flag_now()}, 8'h01);
    // R9: ie off releases irq while flag stays
    wr(0, 8'h01); check("R9 ie off", {7'd0, irq_n}, 8'h01);
    rd(0, r); check("R9 flag", r, 8'h01);
    wr(0, 8'h02); rd(0, r); check("R7 clear", r, 8'h02);
    // R8 clear during held match
    @(negedge clk); set_time(4'd1);
    @(negedge clk); check("R8 set", {7'd0, flag_now()}, 8'h01);
    wr(0, 8'h02);
    repeat (4) @(negedge clk); check("R8 held", {7'd0, flag_now()}, 8'h00);
    set_time(4'd0); @(negedge clk);
    check("R8 dropped", {7'd0, flag_now()}, 8'h00);
    set_time(4'd1); @(negedge clk);
    check("R8 return", {7'd0, flag_now()}, 8'h01);
    // R10 clear and rise together
    set_time(4'd0); wr(0, 8'h02);
    @(negedge clk); check("R10 pre", {7'd0, flag_now()}, 8'h00);
    wr_en = 1; addr = 0; wdata = 8'h02; set_time(4'd1);
    @(negedge clk); wr_en = 0;
    check("R10", {7'd0, flag_now()}, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_run++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule